// File: doc/BRIEF.md
# Configurable Dynamic Branch Direction Predictor

This block guesses whether a conditional branch will be taken. A front end presents the branch address on the lookup port. One cycle later the block returns a taken or not-taken guess, together with the table index it used. When the branch resolves, the back end sends the real outcome and that same index to the update port. The update trains the selected table entry and shifts the outcome into a global history register.

The table holds 2^IDX_W entries. Each entry is either a one-bit last-outcome flag or a two-bit saturating counter, chosen by the `CNT_W` parameter. A run-time scheme input picks how the table is indexed:
- by low address bits, so each address has its own entry;
- by the global history alone;
- by the global history XORed with the low address bits.

Different addresses may land on the same entry, and the block allows this.

Top module: `bpred_top`

## Requirements
- R1: After reset the history register is zero and every entry is weakly not taken (value 1 for two-bit entries, 0 for one-bit entries). A first lookup in global scheme therefore returns index 0 and not taken.
- R2: With scheme code 0 (local), the returned index equals the low IDX_W bits of the lookup address.
- R3: With scheme code 1 (global), the returned index equals the history register as it stands in the lookup cycle.
- R4: With scheme code 2 or 3 (hashed), the returned index equals the history register XOR the low IDX_W bits of the address.
- R5: Each accepted update shifts the history left by one and puts the outcome into bit 0 (1 = taken). Cycles without an update leave the history unchanged.
- R6: With two-bit entries, the prediction is the counter's upper bit: values 3 and 2 predict taken, values 1 and 0 predict not taken.
- R7: A taken update increments the two-bit counter, stopping at 3. A not-taken update decrements it, stopping at 0.
- R8: With one-bit entries, each update stores the outcome, and the prediction equals that stored bit.
- R9: An update writes the entry named by its supplied index, whatever the history has become since the lookup.
- R10: When a lookup and an update hit the same entry in one cycle, the lookup returns the value from before the update.
- R11: The response valid is high in exactly the cycles that follow a cycle with a lookup request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scheme | input | 2 | Index scheme: 0 local, 1 global, 2 or 3 hashed |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | ADDR_W | Branch address for the lookup |
| rsp_valid | output | 1 | Lookup response valid, one cycle after the request |
| rsp_taken | output | 1 | Predicted direction, 1 = taken |
| rsp_index | output | IDX_W | Table index used for the lookup |
| up_valid | input | 1 | Resolved-outcome update |
| up_index | input | IDX_W | Table index to train |
| up_taken | input | 1 | Resolved outcome, 1 = taken |

## Verification
The assertions assume that the clock runs and reset is applied for at least one edge. They also assume that the update index is always a value inside the table, which is true because its width equals IDX_W. Apart from that they accept any mix of lookups and updates, including both in one cycle on one entry. The random stimulus draws every port value freely and changes the scheme input from cycle to cycle, so it stays within these assumptions. It also exercises every scheme against one shared, evolving history.

// File: rtl/bpred_pkg.sv
package bpred_pkg;
  typedef enum logic [1:0] {
    SCH_LOCAL  = 2'd0,
    SCH_GLOBAL = 2'd1,
    SCH_HASH   = 2'd2,
    SCH_HASH2  = 2'd3
  } scheme_e;
endpackage

// File: rtl/bpred_index.sv
module bpred_index #(
  parameter int IDX_W  = 6,
  parameter int ADDR_W = 32
) (
  input  bpred_pkg::scheme_e sch,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [IDX_W-1:0]   hist,
  output logic [IDX_W-1:0]   idx
);
  import bpred_pkg::*;

  logic [IDX_W-1:0] addr_lo;
  assign addr_lo = addr[IDX_W-1:0];

  always_comb begin
    unique case (sch)
      SCH_LOCAL:  idx = addr_lo;
      SCH_GLOBAL: idx = hist;
      default:    idx = hist ^ addr_lo;
    endcase
  end
endmodule

// File: rtl/bpred_hist.sv
module bpred_hist #(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_en,
  input  logic             shift_bit,
  output logic [IDX_W-1:0] hist
);
  always_ff @(posedge clk) begin
    if (rst)           hist <= '0;
    else if (shift_en) hist <= {hist[IDX_W-2:0], shift_bit};
  end

  // R5: outcome enters bit 0, older bits move up
  assert_hist_shift_R5: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> (hist[0] == $past(shift_bit)) &&
                 (hist[IDX_W-1:1] == $past(hist[IDX_W-2:0])));

  // R5: no update, no change
  assert_hist_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(hist));
endmodule

// File: rtl/bpred_pht.sv
module bpred_pht #(
  parameter int IDX_W = 6,
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_taken,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken
);
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [CNT_W-1:0] CMAX  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CINIT = CMAX >> 1;

  logic [CNT_W-1:0] tbl [DEPTH];
  logic [CNT_W-1:0] rd_q;
  logic [CNT_W-1:0] cur_w;
  logic [CNT_W-1:0] nxt_w;

  assign cur_w = tbl[wr_idx];

  always_comb begin
    nxt_w = cur_w;
    if (wr_taken) begin
      if (cur_w != CMAX) nxt_w = cur_w + 1'b1;
    end else begin
      if (cur_w != '0)   nxt_w = cur_w - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) tbl[i] <= CINIT;
    end else if (wr_en) begin
      tbl[wr_idx] <= nxt_w;
    end
  end

  // read port sees the array before this edge's write
  always_ff @(posedge clk) begin
    if (rst)        rd_q <= CINIT;
    else if (rd_en) rd_q <= tbl[rd_idx];
  end

  assign rd_taken = rd_q[CNT_W-1];

  // R7 / R8: a taken update never leaves the entry at the bottom state
  assert_taken_nonzero_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_taken) |=> tbl[$past(wr_idx)] != '0);

  // R7 / R8: a not-taken update never leaves the entry at the top state
  assert_nottaken_notmax_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_taken) |=> tbl[$past(wr_idx)] != CMAX);
endmodule

// File: rtl/bpred_top.sv
module bpred_top #(
  parameter int IDX_W  = 6,
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        scheme,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              rsp_valid,
  output logic              rsp_taken,
  output logic [IDX_W-1:0]  rsp_index,
  input  logic              up_valid,
  input  logic [IDX_W-1:0]  up_index,
  input  logic              up_taken
);
  import bpred_pkg::*;

  localparam int CW = (CNT_W < 1) ? 1 : ((CNT_W > 2) ? 2 : CNT_W);

  scheme_e          sch;
  logic [IDX_W-1:0] hist;
  logic [IDX_W-1:0] lk_idx;

  assign sch = scheme_e'(scheme);

  bpred_hist #(.IDX_W(IDX_W)) u_hist (
    .clk(clk), .rst(rst), .shift_en(up_valid), .shift_bit(up_taken), .hist(hist)
  );

  bpred_index #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_idx (
    .sch(sch), .addr(lk_addr), .hist(hist), .idx(lk_idx)
  );

  bpred_pht #(.IDX_W(IDX_W), .CNT_W(CW)) u_pht (
    .clk(clk), .rst(rst),
    .rd_en(lk_valid), .rd_idx(lk_idx), .rd_taken(rsp_taken),
    .wr_en(up_valid), .wr_idx(up_index), .wr_taken(up_taken)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_index <= '0;
    end else begin
      rsp_valid <= lk_valid;
      if (lk_valid) rsp_index <= lk_idx;
    end
  end

  // R11
  assert_rsp_follows_R11: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> rsp_valid);
  assert_rsp_idle_R11: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !rsp_valid);

  // R2: local scheme index comes from the address
  assert_local_index_R2: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && sch == SCH_LOCAL) |=> rsp_index == $past(lk_addr[IDX_W-1:0]));
endmodule

// File: tb/sim_bpred_top.sv
`timescale 1ns/1ps
module sim_bpred_top;
  localparam int IW = 6;
  localparam int AW = 32;
  localparam int DEPTH = 1 << IW;

  logic          clk = 1'b0;
  logic          rst;
  logic [1:0]    scheme;
  logic          lk_valid;
  logic [AW-1:0] lk_addr;
  logic          up_valid;
  logic [IW-1:0] up_index;
  logic          up_taken;
  logic          v2, t2, v1, t1;
  logic [IW-1:0] i2, i1;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  int            m2 [DEPTH];
  int            m1 [DEPTH];
  logic [IW-1:0] ghr;

  always #2 clk = ~clk;

  bpred_top #(.IDX_W(IW), .ADDR_W(AW), .CNT_W(2)) u0 (
    .clk(clk), .rst(rst), .scheme(scheme), .lk_valid(lk_valid), .lk_addr(lk_addr),
    .rsp_valid(v2), .rsp_taken(t2), .rsp_index(i2),
    .up_valid(up_valid), .up_index(up_index), .up_taken(up_taken));

  bpred_top #(.IDX_W(IW), .ADDR_W(AW), .CNT_W(1)) u1 (
    .clk(clk), .rst(rst), .scheme(scheme), .lk_valid(lk_valid), .lk_addr(lk_addr),
    .rsp_valid(v1), .rsp_taken(t1), .rsp_index(i1),
    .up_valid(up_valid), .up_index(up_index), .up_taken(up_taken));

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [IW-1:0] exp_idx(logic [1:0] s, logic [AW-1:0] a, logic [IW-1:0] h);
    if (s == 2'd0)      return a[IW-1:0];
    else if (s == 2'd1) return h;
    else                return h ^ a[IW-1:0];
  endfunction

  function automatic string idx_tag(logic [1:0] s);
    if (s == 2'd0)      return "R2";
    else if (s == 2'd1) return "R3";
    else                return "R4";
  endfunction

  function automatic int sat2(int c, bit t);
    if (t) return (c == 3) ? 3 : c + 1;
    else   return (c == 0) ? 0 : c - 1;
  endfunction

  task automatic step(bit lv, logic [AW-1:0] a, logic [1:0] s, bit uv, logic [IW-1:0] ui, bit ut);
    logic [IW-1:0] ei;
    @(negedge clk);
    lk_valid = lv; lk_addr = a; scheme = s;
    up_valid = uv; up_index = ui; up_taken = ut;
    ei = exp_idx(s, a, ghr);
    @(posedge clk);
    @(negedge clk);
    chk("R11", v2, lv);
    chk("R11", v1, lv);
    if (lv) begin
      chk(idx_tag(s), i2, ei);
      chk(idx_tag(s), i1, ei);
      chk("R6", t2, (m2[ei] >= 2) ? 1 : 0);
      chk("R8", t1, m1[ei]);
    end
    if (uv) begin
      m2[ui] = sat2(m2[ui], ut);
      m1[ui] = ut;
      ghr = {ghr[IW-2:0], ut};
    end
    lk_valid = 0; up_valid = 0;
  endtask

  initial begin
    #400000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [IW-1:0] kept;
    int unused;
    unused = $urandom(32'd1234);
    for (int i = 0; i < DEPTH; i++) begin m2[i] = 1; m1[i] = 0; end
    ghr = '0;
    rst = 1; lk_valid = 0; lk_addr = '0; scheme = 0;
    up_valid = 0; up_index = '0; up_taken = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;

    // R1: reset state, global scheme, index 0 and not taken
    step(1, 32'h1234_5678, 2'd1, 0, 0, 0);
    chk("R1", i2, 0); chk("R1", t2, 0); chk("R1", t1, 0);

    // R7: saturate upward on entry 5, check taken, then saturate downward
    for (int k = 0; k < 4; k++) step(0, 0, 0, 1, 6'd5, 1);
    step(1, 32'h0000_0105, 2'd0, 0, 0, 0);
    chk("R7", t2, 1);
    step(0, 0, 0, 1, 6'd5, 0);
    step(1, 32'h0000_0005, 2'd0, 0, 0, 0);
    chk("R7", t2, 1);   // 3 -> 2 still taken
    chk("R8", t1, 0);   // one-bit follows last outcome
    for (int k = 0; k < 4; k++) step(0, 0, 0, 1, 6'd5, 0);
    step(0, 0, 0, 1, 6'd5, 1);
    step(1, 32'h0000_0005, 2'd0, 0, 0, 0);
    chk("R7", t2, 0);   // 0 -> 1 not taken
    chk("R8", t1, 1);

    // R5: history visible through global index
    step(1, 0, 2'd1, 0, 0, 0);
    chk("R5", i2, ghr);

    // R9: update lands at supplied index after history moved
    step(1, 32'h0000_0009, 2'd2, 0, 0, 0);
    kept = i2;
    step(0, 0, 0, 1, 6'd40, 1);
    step(0, 0, 0, 1, 6'd41, 0);
    step(0, 0, 0, 1, kept, 1);
    step(0, 0, 0, 1, kept, 1);
    step(1, {26'd0, kept}, 2'd0, 0, 0, 0);
    chk("R9", t2, (m2[kept] >= 2) ? 1 : 0);
    chk("R9", t1, 1);

    // R10: same-cycle lookup and update on entry 12 (model holds 1 / 0)
    step(1, 32'h0000_000C, 2'd0, 1, 6'd12, 1);
    chk("R10", t1, 0);
    step(1, 32'h0000_000C, 2'd0, 0, 0, 0);
    chk("R10", t1, 1);

    // random mix across all schemes
    for (int n = 0; n < 3000; n++) begin
      step($urandom_range(0, 1), $urandom, 2'($urandom_range(0, 3)),
           $urandom_range(0, 1), IW'($urandom), $urandom_range(0, 1));
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule